// File: doc/BRIEF.md
# In-System Programming Target Link

This block is the device-side end of a three-wire serial programming link. While an active-low programming pin is held low, it watches a serial clock and a serial data input. It samples both, together with the pin, on the system clock. It assembles 32-bit instructions, most significant bit first, and shifts a reply back on a serial data output. A programmer uses it to erase, program and read back a small program array and a small data array. Both arrays are modelled here as byte-wide register banks that reset to the erased value 0xFF.

Nothing touches the arrays until a programming-enable instruction has been framed since the pin went low. The reply path echoes each received byte one byte later. A programmer can therefore confirm framing by seeing the enable instruction's second byte come back while it sends the third. Serial clock edges count only after a minimum number of system clocks in the preceding phase. A configuration input selects that minimum.

Top module: `isp_target`

## Requirements
- R1: The link operates only while `prog_rst_n` is low. Raising it clears the enable state, the bit count and the reply register, and array contents are kept.
- R2: An instruction is four bytes (32 bits), most significant bit first, with each MOSI bit taken at an accepted SCK rising edge.
- R3: MISO changes only at accepted SCK falling edges. Each reply byte is the byte received just before it. In particular, the second byte of an instruction comes back during its third byte, so 0x53 is returned while the third byte of the enable instruction is sent.
- R4: Enable is the instruction 0xAC, 0x53, x, x. Before enable, erase, writes and reads have no effect, and a read's fourth reply byte is the echoed third byte.
- R5: Framing is not resynchronised by content. After a bit slip, an enable sent misaligned is not recognised, and only a pin pulse restores alignment.
- R6: Chip erase is 0xAC, 0x80, x, x. It sets every byte of both arrays to 0xFF.
- R7: Program-array write is 0x40, addrH, addrL, data. It can only clear bits (new = old AND data), so raising bits needs a chip erase.
- R8: Data-array write is 0xC0, addrH, addrL, data. It replaces the byte with no prior erase.
- R9: A read (0x20 program array, 0xA0 data array, then addrH, addrL, x) returns the byte during the fourth byte. The address is {addrH,addrL} reduced to its low log2(depth) bits.
- R10: After each erase or write, busy holds for BUSY_CLKS system clocks. Erase and writes that complete framing while busy are dropped. Poll 0xF0, x, x, x returns busy in bit 0 of the fourth reply byte.
- R11: A clock phase is valid when it lasts at least 3 system clocks (`fast_clk_sel`=0) or 4 (`fast_clk_sel`=1). A too-short high phase takes no bit and shifts no MISO bit. A rising edge after a too-short low phase is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low; arrays return to 0xFF |
| prog_rst_n | input | 1 | Programming pin, active low, asynchronous |
| sck | input | 1 | Serial clock from programmer, asynchronous |
| mosi | input | 1 | Serial data into the block |
| fast_clk_sel | input | 1 | Selects the 4-clock minimum phase instead of 3 |
| miso | output | 1 | Serial reply data |

## Verification
Some properties are checked on every cycle. The enable state rises only when a fourth byte completes and falls whenever the pin is released. Busy starts only on a completed instruction. The bit counter advances by one per accepted bit. MISO moves only after an accepted falling edge, and an accepted bit never coincides with an accepted falling edge. The bench scenarios cover the data outcomes: the echo content, the AND-only program write against the replacing data-array write, address wrap, dropped writes while busy, misaligned framing after a slip, and rejection of phases one clock below the selected minimum.

// File: rtl/isp_pkg.sv
package isp_pkg;
   typedef logic [7:0] byte_t;

   localparam byte_t OP_CTRL     = 8'hAC;
   localparam byte_t SUB_ENABLE  = 8'h53;
   localparam byte_t SUB_ERASE   = 8'h80;
   localparam byte_t OP_RD_PROG  = 8'h20;
   localparam byte_t OP_WR_PROG  = 8'h40;
   localparam byte_t OP_RD_DATA  = 8'hA0;
   localparam byte_t OP_WR_DATA  = 8'hC0;
   localparam byte_t OP_POLL     = 8'hF0;
   localparam byte_t ERASED      = 8'hFF;
endpackage

// File: rtl/isp_sck_filter.sv
module isp_sck_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_SLOW    = 3,
   parameter int MIN_FAST    = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic mosi,
   input  logic pin_n,
   input  logic fast_sel,
   output logic active,
   output logic bit_commit,
   output logic bit_val,
   output logic fall_ok
);
   localparam int MAXMIN = (MIN_SLOW > MIN_FAST) ? MIN_SLOW : MIN_FAST;
   localparam int CW     = $clog2(MAXMIN + 1);
   localparam logic [CW-1:0] CMAX = '1;

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("isp_sck_filter: SYNC_STAGES must be at least 1");
   end
   if (MIN_SLOW < 2 || MIN_FAST < 2) begin : g_bad_min
      $error("isp_sck_filter: minimum phase lengths must be at least 2");
   end

   logic sck_s, mosi_s, pin_s;

   if (SYNC_STAGES == 1) begin : g_sync_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sck_s  <= 1'b0;
            mosi_s <= 1'b0;
            pin_s  <= 1'b1;
         end else begin
            sck_s  <= sck;
            mosi_s <= mosi;
            pin_s  <= pin_n;
         end
      end
   end else begin : g_sync_chain
      logic [SYNC_STAGES-1:0] sck_q, mosi_q, pin_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sck_q  <= '0;
            mosi_q <= '0;
            pin_q  <= '1;
         end else begin
            sck_q  <= {sck_q[SYNC_STAGES-2:0], sck};
            mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi};
            pin_q  <= {pin_q[SYNC_STAGES-2:0], pin_n};
         end
      end
      assign sck_s  = sck_q[SYNC_STAGES-1];
      assign mosi_s = mosi_q[SYNC_STAGES-1];
      assign pin_s  = pin_q[SYNC_STAGES-1];
   end

   logic          sck_d, armed, hi_ok;
   logic [CW-1:0] cnt, min_len;
   logic          rise, fall, steady_hi;

   assign active    = ~pin_s;
   assign min_len   = fast_sel ? CW'(MIN_FAST) : CW'(MIN_SLOW);
   assign rise      = sck_s & ~sck_d;
   assign fall      = ~sck_s & sck_d;
   assign steady_hi = sck_s & sck_d;

   assign bit_commit = active && armed && steady_hi && (cnt == min_len - CW'(1));
   assign fall_ok    = active && fall && hi_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d   <= 1'b0;
         cnt     <= CMAX;
         armed   <= 1'b0;
         hi_ok   <= 1'b0;
         bit_val <= 1'b0;
      end else begin
         sck_d <= sck_s;
         if (sck_s != sck_d)  cnt <= CW'(1);
         else if (cnt != CMAX) cnt <= cnt + CW'(1);

         if (!active) begin
            armed <= 1'b0;
            hi_ok <= 1'b0;
         end else if (rise) begin
            hi_ok <= 1'b0;
            armed <= (cnt >= min_len);
            bit_val <= mosi_s;
         end else if (fall) begin
            armed <= 1'b0;
            hi_ok <= 1'b0;
         end else if (bit_commit) begin
            armed <= 1'b0;
            hi_ok <= 1'b1;
         end
      end
   end

   assert_commit_not_on_fall_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bit_commit, fall_ok}));
endmodule

// File: rtl/isp_framer.sv
module isp_framer
   import isp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active,
   input  logic       bit_commit,
   input  logic       bit_val,
   input  logic       fall_ok,
   input  byte_t      next_byte,
   output logic       byte_done,
   output logic [1:0] byte_idx,
   output byte_t      byte_val,
   output logic       miso
);
   logic [4:0] bit_idx;
   logic [6:0] in_sr;
   byte_t      out_sr, pend_byte;
   logic       load_pend;

   assign byte_idx  = bit_idx[4:3];
   assign byte_val  = {in_sr, bit_val};
   assign byte_done = active && bit_commit && (bit_idx[2:0] == 3'd7);
   assign miso      = out_sr[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_idx   <= '0;
         in_sr     <= '0;
         out_sr    <= '0;
         pend_byte <= '0;
         load_pend <= 1'b0;
      end else if (!active) begin
         bit_idx   <= '0;
         in_sr     <= '0;
         out_sr    <= '0;
         load_pend <= 1'b0;
      end else begin
         if (bit_commit) begin
            bit_idx <= bit_idx + 5'd1;
            in_sr   <= {in_sr[5:0], bit_val};
         end
         if (byte_done) begin
            pend_byte <= next_byte;
            load_pend <= 1'b1;
         end else if (fall_ok) begin
            if (load_pend) begin
               out_sr    <= pend_byte;
               load_pend <= 1'b0;
            end else begin
               out_sr <= {out_sr[6:0], 1'b0};
            end
         end
      end
   end

   assert_bit_advance_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (bit_commit && active) |=> (bit_idx == $past(bit_idx) + 5'd1));

   assert_miso_on_fall_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(miso) |-> ($past(fall_ok) || !$past(active)));
endmodule

// File: rtl/isp_cmd_core.sv
module isp_cmd_core
   import isp_pkg::*;
#(
   parameter int PROG_DEPTH = 64,
   parameter int DATA_DEPTH = 32,
   parameter int BUSY_CLKS  = 2000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active,
   input  logic       byte_done,
   input  logic [1:0] byte_idx,
   input  byte_t      byte_val,
   output byte_t      next_byte,
   output logic       enabled,
   output logic       busy
);
   localparam int PAW = $clog2(PROG_DEPTH);
   localparam int DAW = $clog2(DATA_DEPTH);
   localparam int BCW = $clog2(BUSY_CLKS + 1);

   if ((1 << PAW) != PROG_DEPTH || (1 << DAW) != DATA_DEPTH || PAW < 1 || DAW < 1)
   begin : g_bad_depth
      $error("isp_cmd_core: array depths must be powers of two, at least 2");
   end
   if (PAW > 16 || DAW > 16) begin : g_bad_span
      $error("isp_cmd_core: array depth exceeds the 16-bit address");
   end
   if (BUSY_CLKS < 1) begin : g_bad_busy
      $error("isp_cmd_core: BUSY_CLKS must be at least 1");
   end

   byte_t          op_q, hi_q, lo_q;
   byte_t          prog_mem [PROG_DEPTH];
   byte_t          data_mem [DATA_DEPTH];
   logic [BCW-1:0] busy_cnt;
   logic [15:0]    rd_addr, wr_addr;
   logic           exec, may_modify, do_enable, do_erase, do_pwr, do_dwr;

   assign busy       = (busy_cnt != '0);
   assign rd_addr    = {hi_q, byte_val};
   assign wr_addr    = {hi_q, lo_q};
   assign exec       = byte_done && (byte_idx == 2'd3);
   assign may_modify = exec && enabled && !busy;
   assign do_enable  = exec && (op_q == OP_CTRL) && (hi_q == SUB_ENABLE);
   assign do_erase   = may_modify && (op_q == OP_CTRL) && (hi_q == SUB_ERASE);
   assign do_pwr     = may_modify && (op_q == OP_WR_PROG);
   assign do_dwr     = may_modify && (op_q == OP_WR_DATA);

   always_comb begin
      next_byte = byte_val;
      if (enabled && byte_idx == 2'd2) begin
         case (op_q)
            OP_RD_PROG: next_byte = prog_mem[rd_addr[PAW-1:0]];
            OP_RD_DATA: next_byte = data_mem[rd_addr[DAW-1:0]];
            OP_POLL:    next_byte = {7'd0, busy};
            default:    next_byte = byte_val;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q <= '0;
         hi_q <= '0;
         lo_q <= '0;
      end else if (byte_done) begin
         case (byte_idx)
            2'd0:    op_q <= byte_val;
            2'd1:    hi_q <= byte_val;
            2'd2:    lo_q <= byte_val;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         enabled <= 1'b0;
      else if (!active)   enabled <= 1'b0;
      else if (do_enable) enabled <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          busy_cnt <= '0;
      else if (do_erase || do_pwr || do_dwr) busy_cnt <= BCW'(BUSY_CLKS);
      else if (busy)                       busy_cnt <= busy_cnt - BCW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < PROG_DEPTH; i++) prog_mem[i] <= ERASED;
         for (int j = 0; j < DATA_DEPTH; j++) data_mem[j] <= ERASED;
      end else if (do_erase) begin
         for (int i = 0; i < PROG_DEPTH; i++) prog_mem[i] <= ERASED;
         for (int j = 0; j < DATA_DEPTH; j++) data_mem[j] <= ERASED;
      end else begin
         if (do_pwr)
            prog_mem[wr_addr[PAW-1:0]] <= prog_mem[wr_addr[PAW-1:0]] & byte_val;
         if (do_dwr)
            data_mem[wr_addr[DAW-1:0]] <= byte_val;
      end
   end

   assert_busy_starts_on_frame_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(byte_done) && $past(byte_idx) == 2'd3 && $past(enabled)));
endmodule

// File: rtl/isp_target.sv
module isp_target
   import isp_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_SLOW    = 3,
   parameter int MIN_FAST    = 4,
   parameter int PROG_DEPTH  = 64,
   parameter int DATA_DEPTH  = 32,
   parameter int BUSY_CLKS   = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic prog_rst_n,
   input  logic sck,
   input  logic mosi,
   input  logic fast_clk_sel,
   output logic miso
);
   logic       active, bit_commit, bit_val, fall_ok;
   logic       byte_done, enabled, busy;
   logic [1:0] byte_idx;
   byte_t      byte_val, next_byte;

   isp_sck_filter #(
      .SYNC_STAGES(SYNC_STAGES), .MIN_SLOW(MIN_SLOW), .MIN_FAST(MIN_FAST)
   ) u_filter (
      .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .pin_n(prog_rst_n),
      .fast_sel(fast_clk_sel), .active(active), .bit_commit(bit_commit),
      .bit_val(bit_val), .fall_ok(fall_ok)
   );

   isp_framer u_framer (
      .clk(clk), .rst_n(rst_n), .active(active), .bit_commit(bit_commit),
      .bit_val(bit_val), .fall_ok(fall_ok), .next_byte(next_byte),
      .byte_done(byte_done), .byte_idx(byte_idx), .byte_val(byte_val), .miso(miso)
   );

   isp_cmd_core #(
      .PROG_DEPTH(PROG_DEPTH), .DATA_DEPTH(DATA_DEPTH), .BUSY_CLKS(BUSY_CLKS)
   ) u_core (
      .clk(clk), .rst_n(rst_n), .active(active), .byte_done(byte_done),
      .byte_idx(byte_idx), .byte_val(byte_val), .next_byte(next_byte),
      .enabled(enabled), .busy(busy)
   );

   assert_enable_on_fourth_byte_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(enabled) |-> ($past(byte_done) && $past(byte_idx) == 2'd3));

   assert_release_clears_enable_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !enabled);
endmodule

// File: tb/isp_target_tb.sv
module isp_target_tb_top;
   localparam int BUSY = 1500;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic prog_rst_n = 1'b1;
   logic sck = 1'b0;
   logic mosi = 1'b0;
   logic fast_clk_sel = 1'b0;
   logic miso;

   int tests = 0;
   int fails = 0;
   int half = 8;

   always #4 clk = ~clk;

   isp_target #(.BUSY_CLKS(BUSY)) dut_i (
      .clk(clk), .rst_n(rst_n), .prog_rst_n(prog_rst_n), .sck(sck),
      .mosi(mosi), .fast_clk_sel(fast_clk_sel), .miso(miso)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [7:0] t0, input logic [7:0] t1, input logic [7:0] t2,
                       input logic [7:0] t3, output logic [31:0] rx);
      logic [31:0] w;
      w = {t0, t1, t2, t3};
      for (int i = 31; i >= 0; i--) begin
         mosi = w[i];
         repeat (half) @(negedge clk);
         rx[i] = miso;
         sck = 1'b1;
         repeat (half) @(negedge clk);
         sck = 1'b0;
      end
   endtask

   task automatic one_bit(input logic b);
      mosi = b;
      repeat (8) @(negedge clk);
      sck = 1'b1;
      repeat (8) @(negedge clk);
      sck = 1'b0;
   endtask

   task automatic pin_pulse();
      prog_rst_n = 1'b1;
      repeat (10) @(negedge clk);
      prog_rst_n = 1'b0;
      repeat (10) @(negedge clk);
   endtask

   task automatic wait_idle();
      repeat (BUSY + 100) @(negedge clk);
   endtask

   task automatic enable_link();
      logic [31:0] rx;
      xfer(8'hAC, 8'h53, 8'h00, 8'h00, rx);
      chk("R3 enable echo", rx[15:8], 8'h53);
   endtask

   task automatic read_data(input logic [15:0] a, output logic [7:0] d);
      logic [31:0] rx;
      xfer(8'hA0, a[15:8], a[7:0], 8'h00, rx);
      d = rx[7:0];
   endtask

   task automatic read_prog(input logic [15:0] a, output logic [7:0] d);
      logic [31:0] rx;
      xfer(8'h20, a[15:8], a[7:0], 8'h00, rx);
      d = rx[7:0];
   endtask

   task automatic t_reset();
      chk("R1 miso idle after reset", {7'd0, miso}, 8'h00);
   endtask

   task automatic t_pre_enable();
      logic [31:0] rx;
      logic [7:0] d;
      xfer(8'hC0, 8'h00, 8'h05, 8'h00, rx);
      chk("R2 byte0 reply is zero after pin low", rx[31:24], 8'h00);
      chk("R3 second byte echoes first", rx[23:16], 8'hC0);
      xfer(8'hA0, 8'h00, 8'h5A, 8'h00, rx);
      chk("R4 read before enable echoes byte 3", rx[7:0], 8'h5A);
      enable_link();
      read_data(16'h0005, d);
      chk("R4 write before enable ignored", d, 8'hFF);
   endtask

   task automatic t_erase_and_prog();
      logic [31:0] rx;
      logic [7:0] d;
      xfer(8'h40, 8'h00, 8'h03, 8'hF0, rx);
      wait_idle();
      read_prog(16'h0003, d);
      chk("R7 program write", d, 8'hF0);
      xfer(8'h40, 8'h00, 8'h03, 8'h3C, rx);
      wait_idle();
      read_prog(16'h0003, d);
      chk("R7 program write only clears bits", d, 8'h30);
      read_prog(16'h0103, d);
      chk("R9 program address wraps", d, 8'h30);
   endtask

   task automatic t_data_write();
      logic [31:0] rx;
      logic [7:0] d;
      xfer(8'hC0, 8'h00, 8'h07, 8'hA5, rx);
      wait_idle();
      xfer(8'hC0, 8'h00, 8'h07, 8'h5A, rx);
      wait_idle();
      read_data(16'h0007, d);
      chk("R8 data write replaces byte", d, 8'h5A);
      read_data(16'h0027, d);
      chk("R9 data address wraps", d, 8'h5A);
   endtask

   task automatic t_busy();
      logic [31:0] rx;
      logic [7:0] d;
      xfer(8'hC0, 8'h00, 8'h05, 8'h11, rx);
      xfer(8'hC0, 8'h00, 8'h06, 8'h33, rx);
      xfer(8'hF0, 8'h00, 8'h00, 8'h00, rx);
      chk("R10 poll reports busy", rx[7:0], 8'h01);
      wait_idle();
      xfer(8'hF0, 8'h00, 8'h00, 8'h00, rx);
      chk("R10 poll reports idle", rx[7:0], 8'h00);
      read_data(16'h0006, d);
      chk("R10 write while busy dropped", d, 8'hFF);
      read_data(16'h0005, d);
      chk("R10 first write kept", d, 8'h11);
   endtask

   task automatic t_chip_erase();
      logic [31:0] rx;
      logic [7:0] d;
      xfer(8'hAC, 8'h80, 8'h00, 8'h00, rx);
      wait_idle();
      read_prog(16'h0003, d);
      chk("R6 erase program array", d, 8'hFF);
      read_data(16'h0007, d);
      chk("R6 erase data array", d, 8'hFF);
      xfer(8'hC0, 8'h00, 8'h01, 8'h12, rx);
      wait_idle();
   endtask

   task automatic t_release();
      logic [7:0] d;
      pin_pulse();
      read_data(16'h0001, d);
      chk("R1 release drops enable", d, 8'h01);
      enable_link();
      read_data(16'h0001, d);
      chk("R1 contents kept over release", d, 8'h12);
   endtask

   task automatic t_slip();
      logic [31:0] rx;
      logic [7:0] d;
      pin_pulse();
      one_bit(1'b0);
      xfer(8'hAC, 8'h53, 8'h00, 8'h00, rx);
      for (int k = 0; k < 31; k++) one_bit(1'b0);
      read_data(16'h0001, d);
      chk("R5 misaligned enable not seen", d, 8'h01);
      pin_pulse();
      enable_link();
      read_data(16'h0001, d);
      chk("R5 realigned after pin pulse", d, 8'h12);
   endtask

   task automatic t_phase();
      logic [31:0] rx;
      logic [7:0] d;
      fast_clk_sel = 1'b0;
      half = 3;
      read_data(16'h0001, d);
      chk("R11 3-clock phases accepted (slow)", d, 8'h12);
      half = 2;
      xfer(8'hC0, 8'h00, 8'h01, 8'h00, rx);
      half = 8;
      read_data(16'h0001, d);
      chk("R11 2-clock phases rejected (slow)", d, 8'h12);
      fast_clk_sel = 1'b1;
      half = 3;
      xfer(8'hC0, 8'h00, 8'h01, 8'h00, rx);
      half = 8;
      read_data(16'h0001, d);
      chk("R11 3-clock phases rejected (fast)", d, 8'h12);
      sck = 1'b1;
      repeat (3) @(negedge clk);
      sck = 1'b0;
      repeat (8) @(negedge clk);
      read_data(16'h0001, d);
      chk("R11 short high glitch ignored", d, 8'h12);
      half = 4;
      read_data(16'h0001, d);
      chk("R11 4-clock phases accepted (fast)", d, 8'h12);
      half = 8;
      fast_clk_sel = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      prog_rst_n = 1'b0;
      repeat (10) @(negedge clk);
      t_pre_enable();
      t_erase_and_prog();
      t_data_write();
      t_busy();
      t_chip_erase();
      t_release();
      t_slip();
      t_phase();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule